// File: doc/BRIEF.md
# I2C Bus Condition Qualifier

This block watches the two wires of an I2C bus and reports START and STOP conditions. A bare SDA edge while SCL is high is not enough. The block measures in system-clock cycles how long SCL was high before the SDA change, and how long SDA and SCL stay put after it. It also measures the whole SCL-high stretch. A candidate that misses any minimum is dropped, so glitches and slow edges never register as bus conditions.

Both bus inputs pass through a two-flop synchronizer before any edge is looked at. A mode input picks one of two sets of minimums: a standard set and a high-speed set. A qualified condition gives a one-cycle pulse on `start_pulse` or `stop_pulse`. It also updates the bus-busy flag. When the controller is a slave, a STOP also raises a one-cycle interrupt request. The block is meant to sit beside an I2C shift engine, which uses the pulses to frame transfers.

Top module: `i2c_cond_detect`

## Requirements
- R1: While reset is held, and directly after it, `start_pulse`, `stop_pulse`, `irq_pulse` and `bus_busy` are all 0.
- R2: A START candidate is SDA going from 1 to 0 in a cycle where SCL was already high in the cycle before. A START that meets R4 to R6 (or R7 in high-speed mode) gives `start_pulse` high for exactly one cycle.
- R3: A STOP candidate is SDA going from 0 to 1 under the same SCL condition. A STOP that meets the timing gives `stop_pulse` high for exactly one cycle. If SDA changes again before a candidate qualifies, that change drops the old candidate and becomes a new candidate.
- R4: Setup, standard mode (`hs_mode`=0). SCL must have been high for more than 13 cycles before the cycle in which SDA changes. A setup of exactly 13 cycles gives no pulse.
- R5: Hold, standard mode. After the cycle of the SDA change, SCL must stay high and SDA unchanged for more than 13 further cycles. If SCL falls after 13 or fewer, there is no pulse.
- R6: Release, standard mode. The SCL-high stretch, counted from SCL rising up to the decision, must exceed 26 cycles.
- R7: High-speed mode (`hs_mode`=1) uses these minimums instead: release more than 4 cycles, setup more than 2 cycles, hold more than 2 cycles.
- R8: `bus_busy` goes to 1 in the same cycle as `start_pulse` and to 0 in the same cycle as `stop_pulse`. Otherwise it holds its value.
- R9: `irq_pulse` is high together with `stop_pulse` when `is_master`=0. It stays low when `is_master`=1 and on every START.
- R10: These SDA changes give no pulse: a change while SCL is low, and a change in the same cycle in which SCL rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every timing count is in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| hs_mode | input | 1 | 0 selects standard minimums, 1 selects high-speed minimums |
| is_master | input | 1 | 1 when the local controller is bus master, 0 when it is a slave |
| start_pulse | output | 1 | One-cycle pulse on a qualified START |
| stop_pulse | output | 1 | One-cycle pulse on a qualified STOP |
| bus_busy | output | 1 | High between a qualified START and the next qualified STOP |
| irq_pulse | output | 1 | One-cycle interrupt request on a STOP seen as a slave |

## Verification
Some properties are checked by assertions on every cycle:
- each pulse lasts a single cycle;
- the synchronized SDA level matches the condition reported;
- a condition is accepted only after SCL has been held high;
- the interrupt never fires without a STOP;
- the busy flag moves only with a pulse.

The cycle-exact setup and hold limits in both modes can only be shown by the bench, which drives lengths just at and just past each limit. The same holds for dropping a candidate when SDA changes back, for changes while SCL is low or rising, and for the interrupt depending on the master/slave input.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

   typedef enum logic [1:0] {
      COND_NONE  = 2'd0,
      COND_START = 2'd1,
      COND_STOP  = 2'd2
   } cond_e;

endpackage

// File: rtl/i2c_cond_sync.sv
module i2c_cond_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_cond_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   // idle bus level is high on both wires
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_sat_cnt.sv
module i2c_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld1,
   input  logic         inc,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] MAXV = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q <= '0;
      else if (clr)         q <= '0;
      else if (ld1)         q <= W'(1);
      else if (inc && q != MAXV) q <= q + 1'b1;
   end

endmodule

// File: rtl/i2c_cond_qual.sv
module i2c_cond_qual
   import i2c_cond_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int STD_RL = 26,
   parameter int STD_SU = 13,
   parameter int STD_HD = 13,
   parameter int HS_RL  = 4,
   parameter int HS_SU  = 2,
   parameter int HS_HD  = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  scl_s,
   input  logic  sda_s,
   input  logic  hs_mode,
   output cond_e hit
);

   localparam logic [CNT_W-1:0] C_STD_RL = CNT_W'(STD_RL);
   localparam logic [CNT_W-1:0] C_STD_SU = CNT_W'(STD_SU);
   localparam logic [CNT_W-1:0] C_STD_HD = CNT_W'(STD_HD);
   localparam logic [CNT_W-1:0] C_HS_RL  = CNT_W'(HS_RL);
   localparam logic [CNT_W-1:0] C_HS_SU  = CNT_W'(HS_SU);
   localparam logic [CNT_W-1:0] C_HS_HD  = CNT_W'(HS_HD);

   logic             scl_q, sda_q;
   logic             sda_edge, cand, fire, pend;
   cond_e            pend_kind;
   logic [CNT_W-1:0] high_cnt, hold_cnt;
   logic [CNT_W-1:0] t_rl, t_su, t_hd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign t_rl = hs_mode ? C_HS_RL : C_STD_RL;
   assign t_su = hs_mode ? C_HS_SU : C_STD_SU;
   assign t_hd = hs_mode ? C_HS_HD : C_STD_HD;

   assign sda_edge = (sda_s != sda_q);
   assign cand     = sda_edge && scl_s && scl_q;

   // cycles SCL has been high before the current sample
   i2c_sat_cnt #(.W(CNT_W)) u_high (
      .clk(clk), .rst_n(rst_n),
      .clr(!scl_s), .ld1(1'b0), .inc(scl_s),
      .q(high_cnt)
   );

   // cycles since the SDA change with bus frozen
   i2c_sat_cnt #(.W(CNT_W)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .clr(!scl_s), .ld1(cand), .inc(pend),
      .q(hold_cnt)
   );

   assign fire = pend && scl_s && !sda_edge &&
                 (hold_cnt > t_hd) && (high_cnt > t_rl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_kind <= COND_NONE;
      end else if (cand) begin
         pend      <= (high_cnt > t_su);
         pend_kind <= sda_s ? COND_STOP : COND_START;
      end else if (!scl_s || fire) begin
         pend      <= 1'b0;
      end
   end

   assign hit = fire ? pend_kind : COND_NONE;

   // R5
   hold_needs_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != COND_NONE) |-> $past(scl_s));

   // R10
   cand_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(scl_q));

endmodule

// File: rtl/i2c_cond_flags.sv
module i2c_cond_flags
   import i2c_cond_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  cond_e hit,
   input  logic  is_master,
   output logic  start_pulse,
   output logic  stop_pulse,
   output logic  bus_busy,
   output logic  irq_pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pulse <= 1'b0;
         stop_pulse  <= 1'b0;
         irq_pulse   <= 1'b0;
         bus_busy    <= 1'b0;
      end else begin
         start_pulse <= (hit == COND_START);
         stop_pulse  <= (hit == COND_STOP);
         irq_pulse   <= (hit == COND_STOP) && !is_master;
         if (hit == COND_START)     bus_busy <= 1'b1;
         else if (hit == COND_STOP) bus_busy <= 1'b0;
      end
   end

   // R9
   irq_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> stop_pulse);

   // R8
   busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> bus_busy);

   // R8
   busy_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_pulse && !stop_pulse) |-> (bus_busy == $past(bus_busy)));

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
   import i2c_cond_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8,
   parameter int STD_RL      = 26,
   parameter int STD_SU      = 13,
   parameter int STD_HD      = 13,
   parameter int HS_RL       = 4,
   parameter int HS_SU       = 2,
   parameter int HS_HD       = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic hs_mode,
   input  logic is_master,
   output logic start_pulse,
   output logic stop_pulse,
   output logic bus_busy,
   output logic irq_pulse
);

   localparam int MAX_T = (STD_RL > HS_RL) ? STD_RL : HS_RL;

   if (MAX_T + 2 >= (1 << CNT_W)) begin : g_bad_width
      $error("i2c_cond_detect: CNT_W too small for the release minimum");
   end
   if (STD_HD < 1 || HS_HD < 1) begin : g_bad_hold
      $error("i2c_cond_detect: hold minimums must be at least 1");
   end

   logic [1:0] bus_s;
   logic       scl_s, sda_s;
   cond_e      hit;

   i2c_cond_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({scl_in, sda_in}), .q(bus_s)
   );

   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   i2c_cond_qual #(
      .CNT_W(CNT_W),
      .STD_RL(STD_RL), .STD_SU(STD_SU), .STD_HD(STD_HD),
      .HS_RL(HS_RL),   .HS_SU(HS_SU),   .HS_HD(HS_HD)
   ) u_qual (
      .clk(clk), .rst_n(rst_n),
      .scl_s(scl_s), .sda_s(sda_s), .hs_mode(hs_mode),
      .hit(hit)
   );

   i2c_cond_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .hit(hit), .is_master(is_master),
      .start_pulse(start_pulse), .stop_pulse(stop_pulse),
      .bus_busy(bus_busy), .irq_pulse(irq_pulse)
   );

   // R2
   start_sda_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> !$past(sda_s));

   // R3
   stop_sda_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> $past(sda_s));

   // R2
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   // R3
   stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |=> !stop_pulse);

endmodule

// File: tb/i2c_cond_detect_tb.sv
module i2c_cond_detect_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1, hs = 1'b0, mst = 1'b0;
   logic start_pulse, stop_pulse, bus_busy, irq_pulse;

   int errs = 0;
   int total = 0;
   bit done = 1'b0;
   int exp_q[$];
   string cur_req = "R1";

   always #5 clk = ~clk;

   i2c_cond_detect u_dut (
      .clk(clk), .rst_n(rst_n),
      .scl_in(scl), .sda_in(sda),
      .hs_mode(hs), .is_master(mst),
      .start_pulse(start_pulse), .stop_pulse(stop_pulse),
      .bus_busy(bus_busy), .irq_pulse(irq_pulse)
   );

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // codes: 10 START, 20 STOP, 21 STOP with irq, 99 irq alone
   always @(negedge clk) begin
      if (rst_n && !done && (start_pulse || stop_pulse || irq_pulse)) begin
         int act;
         act = start_pulse ? (10 + (stop_pulse ? 50 : 0) + (irq_pulse ? 1 : 0))
             : stop_pulse  ? (20 + (irq_pulse ? 1 : 0)) : 99;
         if (exp_q.size() == 0) check(1'b0, cur_req, act, 0);
         else begin
            int e;
            e = exp_q.pop_front();
            check(act == e, cur_req, act, e);
         end
      end
   end

   task automatic drain(string req);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
      exp_q.delete();
   endtask

   // SCL low, SDA preset; SCL rises; after su cycles SDA moves; after hd cycles SCL drops
   task automatic cond_seq(bit rise, int su, int hd, bit expect_hit, string req);
      cur_req = req;
      scl = 1'b0; sda = !rise;
      wait_cyc(4);
      if (expect_hit) exp_q.push_back(rise ? (mst ? 20 : 21) : 10);
      scl = 1'b1;
      wait_cyc(su);
      sda = rise;
      wait_cyc(hd);
      scl = 1'b0;
      wait_cyc(8);
      drain(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++; total++;
         $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, total);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      // R1 outputs during reset
      check({start_pulse, stop_pulse, irq_pulse, bus_busy} == 4'b0, "R1", 
            {start_pulse, stop_pulse, irq_pulse, bus_busy}, 0);
      rst_n = 1'b1;
      wait_cyc(6);
      check({start_pulse, stop_pulse, irq_pulse, bus_busy} == 4'b0, "R1",
            {start_pulse, stop_pulse, irq_pulse, bus_busy}, 0);

      // standard mode, slave
      cond_seq(1'b0, 14, 15, 1'b1, "R2 R4 R5 R6 start at minimum");
      check(bus_busy == 1'b1, "R8", bus_busy, 1);
      cond_seq(1'b1, 14, 15, 1'b1, "R3 R9 stop at minimum");
      check(bus_busy == 1'b0, "R8", bus_busy, 0);
      cond_seq(1'b0, 13, 20, 1'b0, "R4 start setup 13");
      check(bus_busy == 1'b0, "R4", bus_busy, 0);
      cond_seq(1'b0, 20, 14, 1'b0, "R5 start hold 13");
      cond_seq(1'b0, 20, 20, 1'b1, "R2 R6 long start");
      cond_seq(1'b1, 13, 20, 1'b0, "R4 stop setup 13");
      check(bus_busy == 1'b1, "R4", bus_busy, 1);
      cond_seq(1'b1, 20, 14, 1'b0, "R5 stop hold 13");
      cond_seq(1'b1, 30, 30, 1'b1, "R3 R6 long stop");
      check(bus_busy == 1'b0, "R8", bus_busy, 0);

      // R10 SDA toggles while SCL low
      cur_req = "R10 sda move with scl low";
      scl = 1'b0; wait_cyc(4);
      sda = 1'b0; wait_cyc(20); sda = 1'b1; wait_cyc(20); sda = 1'b0; wait_cyc(8);
      drain("R10");
      // R10 SDA moves in the same cycle SCL rises
      cur_req = "R10 sda with scl rise";
      sda = 1'b1; wait_cyc(4);
      scl = 1'b1; sda = 1'b0; wait_cyc(30);
      scl = 1'b0; wait_cyc(8);
      drain("R10");
      check(bus_busy == 1'b0, "R10", bus_busy, 0);

      // R3 failed START followed by SDA rising back: only a STOP
      cur_req = "R3 sda bounce";
      sda = 1'b1; wait_cyc(4);
      exp_q.push_back(21);
      scl = 1'b1; wait_cyc(15);
      sda = 1'b0; wait_cyc(3);
      sda = 1'b1; wait_cyc(20);
      scl = 1'b0; wait_cyc(8);
      drain("R3");

      // R9 as master: STOP gives no interrupt
      mst = 1'b1;
      cond_seq(1'b0, 20, 20, 1'b1, "R9 master start");
      cond_seq(1'b1, 20, 20, 1'b1, "R9 master stop no irq");
      mst = 1'b0;

      // R7 high-speed minimums
      hs = 1'b1;
      wait_cyc(2);
      cond_seq(1'b0, 3, 4, 1'b1, "R7 hs start at minimum");
      check(bus_busy == 1'b1, "R7", bus_busy, 1);
      cond_seq(1'b1, 2, 20, 1'b0, "R7 hs stop setup 2");
      cond_seq(1'b1, 3, 3, 1'b0, "R7 hs stop hold 2");
      check(bus_busy == 1'b1, "R7", bus_busy, 1);
      cond_seq(1'b1, 3, 4, 1'b1, "R7 hs stop at minimum");
      check(bus_busy == 1'b0, "R7", bus_busy, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
   end

endmodule